// File: doc/BRIEF.md
# Audio Codec Power-Up and Configuration Sequencer

This block brings an audio codec from cold to configured without software help. Out of reset it turns on the codec's supply and amplifier enable while the codec's active-low reset and the mute line stay asserted. It waits a power-settling interval and then releases reset. After a second wake-up interval it starts writing configuration bytes to a byte-oriented serial master.

The serial master is a separate block. It takes a command byte, one or two payload bytes, a payload length and a one-cycle start pulse, and it answers each transfer with a one-cycle done pulse. The first write sets the soft-reset bit in the codec's status register. The codec's reset pin is then pulsed low for a fixed number of clocks, and the status register is rewritten with that bit cleared. A fixed programming list follows: five direct-register writes and then six two-byte extended-register writes. When the last write is acknowledged, a configured flag rises and mute is released.

All intervals are parameters counted in system clocks. At the default of a 50 MHz clock each wait is about 100 ms, and a simulation can override them with short values.

Top module: `codec_power_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled, `pwr_en_o` is 0, `codec_rst_n_o` is 0, `mute_o` is 1, `cfg_done_o` is 0 and `req_start_o` is 0.
- R2: `pwr_en_o` is 1 from the first clock edge after reset release and stays 1. `codec_rst_n_o` stays 0 and `mute_o` stays 1 until edge PWR_CYCLES after release, and `codec_rst_n_o` is 1 after that edge.
- R3: The first `req_start_o` pulse is seen after edge PWR_CYCLES + WAKE_CYCLES + 1 after release and never earlier.
- R4: Every command byte is {DEV_ADDR[5:0], selector[1:0]}. The selector is 2'b10 for status writes and 2'b00 for data and extended writes. `req_len_o` is 1 for single-byte writes and 2 for extended writes, and `req_b1_o` is 0 when the length is 1.
- R5: The first write is a status write of {1'b0, 1'b1, STAT0_CFG}, so bit 6 is the soft-reset bit. On the edge that samples its done, `codec_rst_n_o` falls and stays low for exactly PULSE_CYCLES cycles. The next write is {1'b0, 1'b0, STAT0_CFG} and starts one cycle after `codec_rst_n_o` rises.
- R6: The direct list is written next, in this order: status 0 {0,0,STAT0_CFG}, status 1 {1,STAT1_CFG}, data 0 {2'b00,VOLUME}, data 1 {2'b01,BASS,TREBLE} and data 2 {2'b10,DATA2_FLAGS}.
- R7: Extended registers k = 0 to 5 are written in increasing order. The first payload byte is {5'b11000, k[2:0]} and the second is {3'b111, EXT_VALS[5k+4:5k]}.
- R8: `req_start_o` is a one-cycle pulse, and no new start appears while a transfer is unacknowledged. After a done (other than the soft-reset write's), the next start is seen two edges after the edge that samples the done.
- R9: A `req_done_i` pulse while no transfer is outstanding has no effect on any output or on the timing of the sequence.
- R10: On the edge that samples the final extended write's done, `cfg_done_o` rises and `mute_o` falls. Both hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en_o | output | 1 | Codec supply and amplifier enable |
| codec_rst_n_o | output | 1 | Codec hardware reset, active low |
| mute_o | output | 1 | Output mute, high until configured |
| cfg_done_o | output | 1 | Configuration complete |
| req_start_o | output | 1 | One-cycle start to the serial master |
| req_cmd_o | output | 8 | Command (address) byte |
| req_len_o | output | 2 | Payload byte count, 1 or 2 |
| req_b0_o | output | 8 | First payload byte |
| req_b1_o | output | 8 | Second payload byte, 0 if unused |
| req_done_i | input | 1 | One-cycle completion from the serial master |

## Verification
A wrong step index shows up at once in the command or payload bytes of the next start pulse. A lost or doubled done shows up as a start that is missing or early, checked to the exact cycle. A miscounted interval timer shifts the reset release, the first start or the width of the reset pulse by whole cycles, and the bench samples each of these edges exactly rather than within a window. A stuck outstanding flag either hangs the sequence, which the configured flag never rising exposes, or lets a stray done skip a write, which the ordered payload comparison exposes on the following transfer.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_WAKE,
    ST_ISSUE,
    ST_WAIT,
    ST_PULSE,
    ST_READY
  } seq_state_t;

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
  } cfg_write_t;

  localparam logic [1:0] SEL_STATUS = 2'b10;
  localparam logic [1:0] SEL_DATA   = 2'b00;

  localparam int N_DIRECT  = 5;
  localparam int N_EXT     = 6;
  localparam int N_WRITES  = 2 + N_DIRECT + N_EXT;
  localparam int IDX_W     = $clog2(N_WRITES);

  function automatic cfg_write_t make_write(input logic [7:0] cmd,
                                            input logic [1:0] len,
                                            input logic [7:0] b0,
                                            input logic [7:0] b1);
    cfg_write_t w;
    w.cmd = cmd;
    w.len = len;
    w.b0  = b0;
    w.b1  = (len == 2'd2) ? b1 : 8'h00;
    return w;
  endfunction

endpackage

// File: rtl/cseq_interval_timer.sv
module cseq_interval_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] limit_m1;

  assign limit_m1 = limit - TW'(1);
  assign expire   = run && (cnt == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/cseq_write_table.sv
module cseq_write_table
  import codec_seq_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR    = 6'h05,
  parameter logic [5:0]  STAT0_CFG   = 6'h24,
  parameter logic [6:0]  STAT1_CFG   = 7'h43,
  parameter logic [5:0]  VOLUME      = 6'd20,
  parameter logic [3:0]  BASS        = 4'd0,
  parameter logic [1:0]  TREBLE      = 2'd0,
  parameter logic [5:0]  DATA2_FLAGS = 6'h04,
  parameter logic [29:0] EXT_VALS    = {5'd0, 5'd0, 5'd0, 5'd30, 5'd4, 5'd4}
) (
  input  logic [IDX_W-1:0] idx,
  output cfg_write_t       entry
);
  localparam logic [7:0] CMD_STATUS = {DEV_ADDR, SEL_STATUS};
  localparam logic [7:0] CMD_DATA   = {DEV_ADDR, SEL_DATA};
  localparam int         EXT_BASE   = 2 + N_DIRECT;

  cfg_write_t ext_rows [N_EXT];

  genvar k;
  generate
    for (k = 0; k < N_EXT; k++) begin : g_ext
      assign ext_rows[k] = make_write(CMD_DATA, 2'd2,
                                      {5'b11000, 3'(k)},
                                      {3'b111, EXT_VALS[5*k +: 5]});
    end
  endgenerate

  always_comb begin
    entry = make_write(CMD_DATA, 2'd1, 8'h00, 8'h00);
    if (int'(idx) >= EXT_BASE && int'(idx) < N_WRITES) begin
      entry = ext_rows[int'(idx) - EXT_BASE];
    end else begin
      case (idx)
        IDX_W'(0): entry = make_write(CMD_STATUS, 2'd1, {2'b01, STAT0_CFG}, 8'h00);
        IDX_W'(1): entry = make_write(CMD_STATUS, 2'd1, {2'b00, STAT0_CFG}, 8'h00);
        IDX_W'(2): entry = make_write(CMD_STATUS, 2'd1, {2'b00, STAT0_CFG}, 8'h00);
        IDX_W'(3): entry = make_write(CMD_STATUS, 2'd1, {1'b1, STAT1_CFG}, 8'h00);
        IDX_W'(4): entry = make_write(CMD_DATA, 2'd1, {2'b00, VOLUME}, 8'h00);
        IDX_W'(5): entry = make_write(CMD_DATA, 2'd1, {2'b01, BASS, TREBLE}, 8'h00);
        IDX_W'(6): entry = make_write(CMD_DATA, 2'd1, {2'b10, DATA2_FLAGS}, 8'h00);
        default:   entry = make_write(CMD_DATA, 2'd1, 8'h00, 8'h00);
      endcase
    end
  end
endmodule

// File: rtl/cseq_req_port.sv
module cseq_req_port
  import codec_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  cfg_write_t entry,
  input  logic       done_i,
  output logic       ack,
  output logic       start_o,
  output logic [7:0] cmd_o,
  output logic [1:0] len_o,
  output logic [7:0] b0_o,
  output logic [7:0] b1_o
);
  logic busy;

  assign ack = busy && done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      start_o <= 1'b0;
      cmd_o   <= '0;
      len_o   <= '0;
      b0_o    <= '0;
      b1_o    <= '0;
    end else begin
      start_o <= issue && !busy;
      if (issue && !busy) begin
        busy  <= 1'b1;
        cmd_o <= entry.cmd;
        len_o <= entry.len;
        b0_o  <= entry.b0;
        b1_o  <= entry.b1;
      end else if (ack) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/codec_power_seq.sv
module codec_power_seq
  import codec_seq_pkg::*;
#(
  parameter int          PWR_CYCLES   = 5_000_000,
  parameter int          WAKE_CYCLES  = 5_000_000,
  parameter int          PULSE_CYCLES = 50,
  parameter logic [5:0]  DEV_ADDR     = 6'h05,
  parameter logic [5:0]  STAT0_CFG    = 6'h24,
  parameter logic [6:0]  STAT1_CFG    = 7'h43,
  parameter logic [5:0]  VOLUME       = 6'd20,
  parameter logic [3:0]  BASS         = 4'd0,
  parameter logic [1:0]  TREBLE       = 2'd0,
  parameter logic [5:0]  DATA2_FLAGS  = 6'h04,
  parameter logic [29:0] EXT_VALS     = {5'd0, 5'd0, 5'd0, 5'd30, 5'd4, 5'd4}
) (
  input  logic       clk,
  input  logic       rst,
  output logic       pwr_en_o,
  output logic       codec_rst_n_o,
  output logic       mute_o,
  output logic       cfg_done_o,
  output logic       req_start_o,
  output logic [7:0] req_cmd_o,
  output logic [1:0] req_len_o,
  output logic [7:0] req_b0_o,
  output logic [7:0] req_b1_o,
  input  logic       req_done_i
);
  localparam int MAX_A   = (PWR_CYCLES > WAKE_CYCLES) ? PWR_CYCLES : WAKE_CYCLES;
  localparam int MAX_CYC = (MAX_A > PULSE_CYCLES) ? MAX_A : PULSE_CYCLES;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WRITES - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [TW-1:0]    limit;
  logic             run, expire, issue, ack;
  cfg_write_t       entry;

  always_comb begin
    run   = 1'b1;
    limit = TW'(PWR_CYCLES);
    case (state)
      ST_POWER: limit = TW'(PWR_CYCLES);
      ST_WAKE:  limit = TW'(WAKE_CYCLES);
      ST_PULSE: limit = TW'(PULSE_CYCLES);
      default:  run   = 1'b0;
    endcase
  end

  assign issue = (state == ST_ISSUE);

  cseq_interval_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .limit  (limit),
    .expire (expire)
  );

  cseq_write_table #(
    .DEV_ADDR    (DEV_ADDR),
    .STAT0_CFG   (STAT0_CFG),
    .STAT1_CFG   (STAT1_CFG),
    .VOLUME      (VOLUME),
    .BASS        (BASS),
    .TREBLE      (TREBLE),
    .DATA2_FLAGS (DATA2_FLAGS),
    .EXT_VALS    (EXT_VALS)
  ) u_table (
    .idx   (idx),
    .entry (entry)
  );

  cseq_req_port u_port (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .entry   (entry),
    .done_i  (req_done_i),
    .ack     (ack),
    .start_o (req_start_o),
    .cmd_o   (req_cmd_o),
    .len_o   (req_len_o),
    .b0_o    (req_b0_o),
    .b1_o    (req_b1_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_POWER;
      idx           <= '0;
      pwr_en_o      <= 1'b0;
      codec_rst_n_o <= 1'b0;
      mute_o        <= 1'b1;
      cfg_done_o    <= 1'b0;
    end else begin
      pwr_en_o <= 1'b1;
      case (state)
        ST_POWER: if (expire) begin
          codec_rst_n_o <= 1'b1;
          state         <= ST_WAKE;
        end
        ST_WAKE: if (expire) begin
          idx   <= '0;
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (ack) begin
          if (idx == '0) begin
            codec_rst_n_o <= 1'b0;
            state         <= ST_PULSE;
          end else if (idx == LAST_IDX) begin
            cfg_done_o <= 1'b1;
            mute_o     <= 1'b0;
            state      <= ST_READY;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= ST_ISSUE;
          end
        end
        ST_PULSE: if (expire) begin
          codec_rst_n_o <= 1'b1;
          idx           <= IDX_W'(1);
          state         <= ST_ISSUE;
        end
        ST_READY: state <= ST_READY;
        default:  state <= ST_POWER;
      endcase
    end
  end
endmodule

// File: rtl/codec_power_seq_checker.sv
module codec_power_seq_checker #(
  parameter logic [5:0] DEV_ADDR = 6'h05
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_en_o,
  input logic       codec_rst_n_o,
  input logic       mute_o,
  input logic       cfg_done_o,
  input logic       req_start_o,
  input logic [7:0] req_cmd_o,
  input logic [1:0] req_len_o,
  input logic       req_done_i
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)              pending <= 1'b0;
    else if (req_start_o) pending <= 1'b1;
    else if (req_done_i)  pending <= 1'b0;
  end

  p_supply_first_r2: assert property (@(posedge clk) disable iff (rst)
    codec_rst_n_o |-> pwr_en_o);

  p_cmd_addr_r4: assert property (@(posedge clk) disable iff (rst)
    req_start_o |-> (req_cmd_o[7:2] == DEV_ADDR));

  p_len_legal_r4: assert property (@(posedge clk) disable iff (rst)
    req_start_o |-> (req_len_o == 2'd1 || req_len_o == 2'd2));

  p_no_write_in_reset_r5: assert property (@(posedge clk) disable iff (rst)
    !codec_rst_n_o |-> !req_start_o);

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    req_start_o |=> !req_start_o);

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
    req_start_o |-> !pending);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_done_o |=> cfg_done_o);

  p_mute_tracks_r10: assert property (@(posedge clk) disable iff (rst)
    mute_o != cfg_done_o);

  p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_done_o |-> !req_start_o);
endmodule

bind codec_power_seq codec_power_seq_checker #(.DEV_ADDR(DEV_ADDR)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .pwr_en_o      (pwr_en_o),
  .codec_rst_n_o (codec_rst_n_o),
  .mute_o        (mute_o),
  .cfg_done_o    (cfg_done_o),
  .req_start_o   (req_start_o),
  .req_cmd_o     (req_cmd_o),
  .req_len_o     (req_len_o),
  .req_done_i    (req_done_i)
);

// File: tb/tb_codec_power_seq.sv
module tb_codec_power_seq;
  localparam int PWR   = 20;
  localparam int WAKE  = 15;
  localparam int PULSE = 5;
  localparam int NW    = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_done_i = 1'b0;
  logic       pwr_en_o, codec_rst_n_o, mute_o, cfg_done_o, req_start_o;
  logic [7:0] req_cmd_o, req_b0_o, req_b1_o;
  logic [1:0] req_len_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  codec_power_seq #(
    .PWR_CYCLES   (PWR),
    .WAKE_CYCLES  (WAKE),
    .PULSE_CYCLES (PULSE)
  ) dut (
    .clk           (clk),
    .rst           (rst),
    .pwr_en_o      (pwr_en_o),
    .codec_rst_n_o (codec_rst_n_o),
    .mute_o        (mute_o),
    .cfg_done_o    (cfg_done_o),
    .req_start_o   (req_start_o),
    .req_cmd_o     (req_cmd_o),
    .req_len_o     (req_len_o),
    .req_b0_o      (req_b0_o),
    .req_b1_o      (req_b1_o),
    .req_done_i    (req_done_i)
  );

  // {cmd, len, b0, b1, done latency in cycles}
  localparam logic [31:0] VEC [NW] = '{
    {8'h16, 4'd1, 8'h64, 8'h00, 4'd2},
    {8'h16, 4'd1, 8'h24, 8'h00, 4'd1},
    {8'h16, 4'd1, 8'h24, 8'h00, 4'd3},
    {8'h16, 4'd1, 8'hC3, 8'h00, 4'd1},
    {8'h14, 4'd1, 8'h14, 8'h00, 4'd4},
    {8'h14, 4'd1, 8'h40, 8'h00, 4'd2},
    {8'h14, 4'd1, 8'h84, 8'h00, 4'd1},
    {8'h14, 4'd2, 8'hC0, 8'hE4, 4'd3},
    {8'h14, 4'd2, 8'hC1, 8'hE4, 4'd1},
    {8'h14, 4'd2, 8'hC2, 8'hFE, 4'd2},
    {8'h14, 4'd2, 8'hC3, 8'hE0, 4'd4},
    {8'h14, 4'd2, 8'hC4, 8'hE0, 4'd1},
    {8'h14, 4'd2, 8'hC5, 8'hE0, 4'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state(input string req);
    chk(pwr_en_o == 1'b0, req, "pwr_en in reset", pwr_en_o, 0);
    chk(codec_rst_n_o == 1'b0, req, "codec_rst_n in reset", codec_rst_n_o, 0);
    chk(mute_o == 1'b1, req, "mute in reset", mute_o, 1);
    chk(cfg_done_o == 1'b0, req, "cfg_done in reset", cfg_done_o, 0);
    chk(req_start_o == 1'b0, req, "req_start in reset", req_start_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rise_cyc;
    int start_cyc;
    int guard;
    logic [31:0] v;
    string tag;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;

    // R2/R3/R9: power and wake windows, with a stray done inside them
    rise_cyc = -1;
    guard = 0;
    @(negedge clk);
    while (!req_start_o && guard < 200) begin
      if (cyc == 1) chk(pwr_en_o == 1'b1, "R2", "pwr_en after release", pwr_en_o, 1);
      if (rise_cyc < 0 && codec_rst_n_o) rise_cyc = cyc;
      if (cyc < PWR && mute_o != 1'b1)
        chk(1'b0, "R2", "mute during power wait", mute_o, 1);
      req_done_i = (cyc == 5);
      @(negedge clk);
      guard++;
    end
    req_done_i = 1'b0;
    start_cyc = cyc;
    chk(rise_cyc == PWR, "R2", "codec reset release cycle", rise_cyc, PWR);
    chk(start_cyc == PWR + WAKE + 1, "R3", "first start cycle", start_cyc, PWR + WAKE + 1);
    chk(start_cyc == PWR + WAKE + 1, "R9", "stray done left timing unchanged", start_cyc, PWR + WAKE + 1);

    // Table walk: R4..R8, R10
    for (int i = 0; i < NW; i++) begin
      v = VEC[i];
      if (i < 2) tag = "R5";
      else if (i < 7) tag = "R6";
      else tag = "R7";
      chk(req_start_o == 1'b1, tag, $sformatf("start for write %0d", i), req_start_o, 1);
      chk(req_cmd_o == v[31:24], "R4", $sformatf("cmd of write %0d", i), req_cmd_o, v[31:24]);
      chk(req_len_o == v[23:20], "R4", $sformatf("len of write %0d", i), req_len_o, v[23:20]);
      chk(req_b0_o == v[19:12], tag, $sformatf("byte0 of write %0d", i), req_b0_o, v[19:12]);
      chk(req_b1_o == v[11:4], tag, $sformatf("byte1 of write %0d", i), req_b1_o, v[11:4]);
      chk(codec_rst_n_o == 1'b1, "R5", "codec out of reset during write", codec_rst_n_o, 1);
      for (int w = 0; w < int'(v[3:0]); w++) begin
        @(negedge clk);
        chk(req_start_o == 1'b0, "R8", "start held while outstanding", req_start_o, 0);
      end
      req_done_i = 1'b1;
      @(negedge clk);
      req_done_i = 1'b0;
      if (i == NW - 1) begin
        chk(cfg_done_o == 1'b1, "R10", "cfg_done after last done", cfg_done_o, 1);
        chk(mute_o == 1'b0, "R10", "mute released after last done", mute_o, 0);
      end else begin
        chk(cfg_done_o == 1'b0, "R10", "cfg_done before last done", cfg_done_o, 0);
      end
      if (i == 0) begin
        int low_cnt;
        int gap;
        low_cnt = 0;
        gap = 0;
        while (!req_start_o && gap < 100) begin
          if (!codec_rst_n_o) low_cnt++;
          @(negedge clk);
          gap++;
        end
        chk(low_cnt == PULSE, "R5", "hardware reset pulse width", low_cnt, PULSE);
        chk(gap == PULSE + 1, "R5", "clear write follows release", gap, PULSE + 1);
      end else if (i < NW - 1) begin
        @(negedge clk);
        chk(req_start_o == 1'b1, "R8", "next start two edges after done", req_start_o, 1);
      end
    end

    // R9/R10: stray done after configuration, flags hold
    req_done_i = 1'b1;
    @(negedge clk);
    req_done_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 0 || k == 9) begin
        chk(cfg_done_o == 1'b1, "R10", "cfg_done holds", cfg_done_o, 1);
        chk(mute_o == 1'b0, "R10", "mute stays released", mute_o, 0);
        chk(req_start_o == 1'b0, "R9", "no start after stray done", req_start_o, 0);
        chk(codec_rst_n_o == 1'b1, "R9", "codec reset unaffected", codec_rst_n_o, 1);
      end
    end

    // R1/R10: reset clears a configured block, sequence restarts
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R1");
    chk(cfg_done_o == 1'b0, "R10", "reset clears cfg_done", cfg_done_o, 0);
    rst = 1'b0;
    rise_cyc = -1;
    guard = 0;
    @(negedge clk);
    while (rise_cyc < 0 && guard < 100) begin
      if (codec_rst_n_o) rise_cyc = cyc;
      else @(negedge clk);
      guard++;
    end
    chk(rise_cyc == PWR, "R2", "release cycle after second reset", rise_cyc, PWR);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule